// File: doc/BRIEF.md
# Two-Source Lane Permute Unit

This block assembles a 128-bit or 256-bit vector from two data vectors. A third vector supplies one control field for each destination element. The control field chooses which data vector the element comes from and which element of the same 128-bit lane is copied. It can also force the element to zero. Elements are either four 32-bit values or two 64-bit values per lane. Data never moves from one lane into another.

A datapath next to the register file uses it. The first data vector always arrives on its own port. Two more operands arrive from the register-addressed source and from the immediate-addressed source. A swap bit decides which of these two is the second data vector and which is the control vector. The unit also returns the register number held in the upper immediate nibble, after masking it for the current addressing mode. The result is captured in an output register. The same permute can be built as pure combinational logic through a parameter.

Top module: `vperm2_unit`

## Requirements
- R1: In 32-bit element mode (`dbl`=0), destination dword n of a lane copies the source dword whose in-lane index equals bits [1:0] of control dword n of that lane.
- R2: Control bit 2 picks the source. When it is set, the data comes from `src_a`. When it is clear, the data comes from the second data vector.
- R3: In 64-bit element mode (`dbl`=1), destination qword n of a lane is governed by control dword 2n of that lane, and bit 1 of that dword picks the source qword. Control bit 0 and the odd control dwords have no effect.
- R4: The zero mode is `imm8[1:0]`. A destination element is all zeros in two cases: the mode is 2 and control bit 3 is 1, or the mode is 3 and control bit 3 is 0. Modes 0 and 1 never force zeros.
- R5: When `swap_w`=1, `src_ireg` is the second data vector and `src_rm` is the control vector. When `swap_w`=0 the two roles are exchanged.
- R6: When `wide`=1, the upper 128-bit lane is permuted from the upper lanes of its operands only, independently of the lower lane.
- R7: When `wide`=0, `result[255:128]` is zero.
- R8: `reg_idx` equals `imm8[7:4]` when `long_mode`=1 and `{1'b0, imm8[6:4]}` when `long_mode`=0.
- R9: `result` and `reg_idx` are registered: they reflect the inputs present at the previous rising clock edge, and they are zero while `rst_n` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the output stage |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_a | input | 256 | First data vector, chosen when control bit 2 is set |
| src_rm | input | 256 | Register-addressed operand |
| src_ireg | input | 256 | Immediate-addressed operand |
| imm8 | input | 8 | Immediate: [1:0] zero mode, [7:4] register number |
| swap_w | input | 1 | Operand role swap |
| wide | input | 1 | 1 = 256-bit length, 0 = 128-bit length |
| dbl | input | 1 | 1 = 64-bit elements, 0 = 32-bit elements |
| long_mode | input | 1 | 1 = four-bit register numbers allowed |
| result | output | 256 | Permuted vector |
| reg_idx | output | 4 | Resolved register number from the immediate |

## Verification
The only state in this block is the output register, and the faults that matter are wrong selector wiring. A fault like this shows at the port one clock after the offending inputs are applied. It affects only the dwords whose control field uses the broken path, for example one element index, one source choice, one zero mode or the upper lane. For this reason the bench compares the full 256-bit result and the register number every cycle, using directed control patterns that isolate each field. It then adds random operands across all modes, so that a fault confined to a single slot cannot hide for long.

// File: rtl/vperm2_pkg.sv
package vperm2_pkg;

  typedef enum logic [1:0] {
    ZM_PASS_A  = 2'd0,
    ZM_PASS_B  = 2'd1,
    ZM_ZERO_HI = 2'd2,
    ZM_ZERO_LO = 2'd3
  } zmode_e;

  // Element is cleared when the mode, folded with control bit 3, reaches all-ones.
  function automatic logic zero_hit(input logic [1:0] zm, input logic ctl_b3);
    return (zm ^ {1'b0, ctl_b3}) == 2'b11;
  endfunction

endpackage

// File: rtl/vperm2_opsel.sv
module vperm2_opsel #(
  parameter int VEC_W = 256,
  parameter int RIDX_W = 4
) (
  input  logic [VEC_W-1:0]  opnd_rm,
  input  logic [VEC_W-1:0]  opnd_ireg,
  input  logic              swap,
  input  logic [RIDX_W-1:0] imm_hi,
  input  logic              lm,
  output logic [VEC_W-1:0]  data2,
  output logic [VEC_W-1:0]  ctl,
  output logic [RIDX_W-1:0] ridx
);

  always_comb begin
    if (swap) begin
      data2 = opnd_ireg;
      ctl   = opnd_rm;
    end else begin
      data2 = opnd_rm;
      ctl   = opnd_ireg;
    end
  end

  // Top register-number bit only reachable in long mode.
  always_comb begin
    ridx = imm_hi;
    if (!lm) ridx[RIDX_W-1] = 1'b0;
  end

endmodule

// File: rtl/vperm2_lane.sv
module vperm2_lane #(
  parameter int LANE_W = 128,
  parameter int EL_W   = 32
) (
  input  logic [LANE_W-1:0] first_i,
  input  logic [LANE_W-1:0] second_i,
  input  logic [LANE_W-1:0] ctl_i,
  input  logic              dbl_i,
  input  logic [1:0]        zmode_i,
  output logic [LANE_W-1:0] lane_o
);
  import vperm2_pkg::*;

  localparam int NSLOT = LANE_W / EL_W;
  localparam int IDX_W = $clog2(NSLOT);

  for (genvar d = 0; d < NSLOT; d++) begin : g_slot
    localparam int PAIR_BASE = (d / 2) * 2 * EL_W;
    localparam logic HALF = d[0];
    logic [EL_W-1:0]   c_word;
    logic [IDX_W-1:0]  idx;
    logic [LANE_W-1:0] src;
    logic [EL_W-1:0]   pick;

    always_comb begin
      // Wide elements share the control word of their even half.
      c_word = dbl_i ? ctl_i[PAIR_BASE +: EL_W] : ctl_i[d*EL_W +: EL_W];
      idx    = dbl_i ? {c_word[1], HALF} : c_word[1:0];
      src    = c_word[2] ? first_i : second_i;
      pick   = src[idx*EL_W +: EL_W];
      lane_o[d*EL_W +: EL_W] = zero_hit(zmode_i, c_word[3]) ? '0 : pick;
    end
  end

endmodule

// File: rtl/vperm2_unit.sv
module vperm2_unit #(
  parameter int VEC_W   = 256,
  parameter int LANE_W  = 128,
  parameter int EL_W    = 32,
  parameter int RIDX_W  = 4,
  parameter bit OUT_REG = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [VEC_W-1:0]  src_a,
  input  logic [VEC_W-1:0]  src_rm,
  input  logic [VEC_W-1:0]  src_ireg,
  input  logic [7:0]        imm8,
  input  logic              swap_w,
  input  logic              wide,
  input  logic              dbl,
  input  logic              long_mode,
  output logic [VEC_W-1:0]  result,
  output logic [RIDX_W-1:0] reg_idx
);

  localparam int NLANES = VEC_W / LANE_W;

  logic [VEC_W-1:0]  data2;
  logic [VEC_W-1:0]  ctl;
  logic [RIDX_W-1:0] ridx_d;
  logic [VEC_W-1:0]  perm;
  logic [VEC_W-1:0]  result_d;

  vperm2_opsel #(.VEC_W(VEC_W), .RIDX_W(RIDX_W)) u_opsel (
    .opnd_rm   (src_rm),
    .opnd_ireg (src_ireg),
    .swap      (swap_w),
    .imm_hi    (imm8[7:4]),
    .lm        (long_mode),
    .data2     (data2),
    .ctl       (ctl),
    .ridx      (ridx_d)
  );

  for (genvar l = 0; l < NLANES; l++) begin : g_lane
    vperm2_lane #(.LANE_W(LANE_W), .EL_W(EL_W)) u_lane (
      .first_i  (src_a[l*LANE_W +: LANE_W]),
      .second_i (data2[l*LANE_W +: LANE_W]),
      .ctl_i    (ctl[l*LANE_W +: LANE_W]),
      .dbl_i    (dbl),
      .zmode_i  (imm8[1:0]),
      .lane_o   (perm[l*LANE_W +: LANE_W])
    );

    // Lane 0 always live; upper lanes only at full length.
    always_comb begin
      if (l == 0 || wide) result_d[l*LANE_W +: LANE_W] = perm[l*LANE_W +: LANE_W];
      else                result_d[l*LANE_W +: LANE_W] = '0;
    end
  end

  if (OUT_REG) begin : g_reg
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        result  <= '0;
        reg_idx <= '0;
      end else begin
        result  <= result_d;
        reg_idx <= ridx_d;
      end
    end
  end else begin : g_comb
    assign result  = result_d;
    assign reg_idx = ridx_d;
  end

endmodule

// File: rtl/vperm2_chk.sv
module vperm2_chk #(
  parameter int VEC_W   = 256,
  parameter int RIDX_W  = 4,
  parameter bit OUT_REG = 1'b1
) (
  input logic              clk,
  input logic              rst_n,
  input logic [VEC_W-1:0]  src_a,
  input logic [VEC_W-1:0]  src_rm,
  input logic [VEC_W-1:0]  src_ireg,
  input logic [7:0]        imm8,
  input logic              swap_w,
  input logic              wide,
  input logic              dbl,
  input logic              long_mode,
  input logic [VEC_W-1:0]  result,
  input logic [RIDX_W-1:0] reg_idx
);

  logic [31:0] ctl0;
  assign ctl0 = swap_w ? src_rm[31:0] : src_ireg[31:0];

  if (OUT_REG) begin : g_props
    // R7: short length clears the upper half
    a_r7_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
      !wide |=> result[VEC_W-1:128] == '0);

    // R8: short addressing never reaches the top register bank
    a_r8_short_idx: assert property (@(posedge clk) disable iff (!rst_n)
      !long_mode |=> reg_idx[RIDX_W-1] == 1'b0);

    // R8: long addressing passes the nibble through
    a_r8_long_idx: assert property (@(posedge clk) disable iff (!rst_n)
      long_mode |=> reg_idx == $past(imm8[7:4]));

    // R4: mode 3 with control bit 3 clear zeroes element 0
    a_r4_zero_lo: assert property (@(posedge clk) disable iff (!rst_n)
      (!dbl && imm8[1:0] == 2'd3 && !ctl0[3]) |=> result[31:0] == '0);

    // R4: mode 2 with control bit 3 set zeroes element 0
    a_r4_zero_hi: assert property (@(posedge clk) disable iff (!rst_n)
      (!dbl && imm8[1:0] == 2'd2 && ctl0[3]) |=> result[31:0] == '0);

    // R2: bit 2 set, index 0, no zeroing mode -> element 0 of src_a
    a_r2_first_src: assert property (@(posedge clk) disable iff (!rst_n)
      (!dbl && !imm8[1] && ctl0[2] && ctl0[1:0] == 2'd0)
        |=> result[31:0] == $past(src_a[31:0]));

    // R9: output is clear on the first edge after reset release
    a_r9_reset_clear: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rst_n) |-> (result == '0 && reg_idx == '0));
  end

endmodule

bind vperm2_unit vperm2_chk #(.VEC_W(VEC_W), .RIDX_W(RIDX_W), .OUT_REG(OUT_REG)) u_chk (.*);

// File: tb/sim_vperm2_unit.sv
module sim_vperm2_unit;
  localparam int CLK_PERIOD = 10;
  localparam int N_RAND = 400;

  logic         clk;
  logic         rst_n;
  logic [255:0] src_a, src_rm, src_ireg;
  logic [7:0]   imm8;
  logic         swap_w, wide, dbl, long_mode;
  logic [255:0] result;
  logic [3:0]   reg_idx;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  logic [255:0] q_res[$];
  logic [3:0]   q_idx[$];
  string        q_tag[$];

  vperm2_unit u0 (
    .clk(clk), .rst_n(rst_n), .src_a(src_a), .src_rm(src_rm), .src_ireg(src_ireg),
    .imm8(imm8), .swap_w(swap_w), .wide(wide), .dbl(dbl), .long_mode(long_mode),
    .result(result), .reg_idx(reg_idx)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  // Behavioural model built from the requirement text.
  function automatic logic [255:0] model(input logic [255:0] a, rm, ir,
                                         input logic [7:0] im, input logic w, wd, d);
    logic [255:0] sec, cv, r;
    int zm;
    r = '0;
    sec = w ? ir : rm;
    cv  = w ? rm : ir;
    zm  = int'(im[1:0]);
    for (int ln = 0; ln < (wd ? 2 : 1); ln++) begin
      int base = ln * 128;
      if (!d) begin
        for (int e = 0; e < 4; e++) begin
          logic [31:0] c = cv[base + e*32 +: 32];
          bit z = (zm == 2 && c[3]) || (zm == 3 && !c[3]);
          int k = int'(c[1:0]);
          r[base + e*32 +: 32] = z ? 32'd0 : (c[2] ? a[base + k*32 +: 32] : sec[base + k*32 +: 32]);
        end
      end else begin
        for (int e = 0; e < 2; e++) begin
          logic [31:0] c = cv[base + e*64 +: 32];
          bit z = (zm == 2 && c[3]) || (zm == 3 && !c[3]);
          int k = int'(c[1]);
          r[base + e*64 +: 64] = z ? 64'd0 : (c[2] ? a[base + k*64 +: 64] : sec[base + k*64 +: 64]);
        end
      end
    end
    return r;
  endfunction

  function automatic logic [255:0] ramp(input logic [31:0] b);
    logic [255:0] v;
    for (int i = 0; i < 8; i++) v[i*32 +: 32] = b + 32'(i);
    return v;
  endfunction

  function automatic logic [255:0] rnd256();
    logic [255:0] v;
    for (int i = 0; i < 8; i++) v[i*32 +: 32] = $urandom;
    return v;
  endfunction

  task automatic check_head();
    logic [255:0] er;
    logic [3:0] ei;
    string t;
    if (q_res.size() == 0) return;
    er = q_res.pop_front();
    ei = q_idx.pop_front();
    t  = q_tag.pop_front();
    checks++;
    if (result !== er || reg_idx !== ei) begin
      errors++;
      $display("FAIL %s: result=%h idx=%h expected result=%h idx=%h", t, result, reg_idx, er, ei);
    end
  endtask

  task automatic apply(input logic [255:0] a, rm, ir, input logic [7:0] im,
                       input logic w, wd, d, lm, input string tag);
    @(negedge clk);
    check_head();
    src_a = a; src_rm = rm; src_ireg = ir; imm8 = im;
    swap_w = w; wide = wd; dbl = d; long_mode = lm;
    q_res.push_back(model(a, rm, ir, im, w, wd, d));
    q_idx.push_back(lm ? im[7:4] : {1'b0, im[6:4]});
    q_tag.push_back(tag);
  endtask

  task automatic finish_run();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: run did not complete, expected completion");
      finish_run();
    end
  end

  initial begin
    logic [255:0] a, b, c, cv;
    rst_n = 1'b0;
    src_a = '1; src_rm = '1; src_ireg = '1; imm8 = 8'hFF;
    swap_w = 1'b1; wide = 1'b1; dbl = 1'b0; long_mode = 1'b1;
    repeat (3) @(negedge clk);
    // R9: outputs held at zero during reset
    checks++;
    if (result !== '0 || reg_idx !== '0) begin
      errors++;
      $display("FAIL R9 reset: result=%h idx=%h expected 0 0", result, reg_idx);
    end
    rst_n = 1'b1;

    a = ramp(32'hA000_0000); b = ramp(32'hB000_0000); c = ramp(32'hC000_0000);

    // R1: reversed index sweep from src_a, imm mode 0
    cv = '0;
    for (int i = 0; i < 8; i++) cv[i*32 +: 32] = 32'h4 | 32'(3 - (i % 4));
    apply(a, b, cv, 8'h00, 1'b0, 1'b1, 1'b0, 1'b1, "R1 index sweep");
    for (int i = 0; i < 8; i++) cv[i*32 +: 32] = 32'(i % 4);
    apply(a, b, cv, 8'h01, 1'b0, 1'b1, 1'b0, 1'b1, "R1 identity second source");

    // R2: alternating source choice
    for (int i = 0; i < 8; i++) cv[i*32 +: 32] = ((i % 2) ? 32'h4 : 32'h0) | 32'((i + 1) % 4);
    apply(a, b, cv, 8'h00, 1'b0, 1'b1, 1'b0, 1'b1, "R2 source select");

    // R3: 64-bit mode, odd control dwords and bit 0 are junk
    for (int i = 0; i < 8; i++) cv[i*32 +: 32] = (i % 2) ? 32'hFFFF_FFF7 : (32'h1 | ((i % 4) ? 32'h2 : 32'h6));
    apply(a, b, cv, 8'h00, 1'b0, 1'b1, 1'b1, 1'b1, "R3 qword select");
    for (int i = 0; i < 8; i++) cv[i*32 +: 32] = (i % 2) ? 32'hA5A5_5A5A : 32'h4;
    apply(a, b, cv, 8'h00, 1'b0, 1'b1, 1'b1, 1'b1, "R3 qword zero index");

    // R4: each zero mode with control bit 3 alternating
    for (int i = 0; i < 8; i++) cv[i*32 +: 32] = ((i % 2) ? 32'h8 : 32'h0) | 32'h4 | 32'(i % 4);
    for (int m = 0; m < 4; m++)
      apply(a, b, cv, 8'(m), 1'b0, 1'b1, 1'b0, 1'b1, $sformatf("R4 zero mode %0d", m));
    apply(a, b, cv, 8'h02, 1'b0, 1'b1, 1'b1, 1'b1, "R4 zero mode 2 qword");
    apply(a, b, cv, 8'h03, 1'b0, 1'b1, 1'b1, 1'b1, "R4 zero mode 3 qword");

    // R5: role swap: control on src_rm, data on src_ireg
    for (int i = 0; i < 8; i++) cv[i*32 +: 32] = 32'(3 - (i % 4));
    apply(a, cv, c, 8'h00, 1'b1, 1'b1, 1'b0, 1'b1, "R5 swap set");
    apply(a, c, cv, 8'h00, 1'b0, 1'b1, 1'b0, 1'b1, "R5 swap clear");

    // R6: upper lane draws only from upper lanes
    for (int i = 0; i < 8; i++) cv[i*32 +: 32] = (i < 4) ? 32'h4 : 32'h3;
    apply(a, b, cv, 8'h00, 1'b0, 1'b1, 1'b0, 1'b1, "R6 lane isolation");

    // R7: short length
    apply(a, b, cv, 8'h00, 1'b0, 1'b0, 1'b0, 1'b1, "R7 short length");
    apply(a, b, cv, 8'h00, 1'b0, 1'b0, 1'b1, 1'b1, "R7 short length qword");

    // R8: register number masking
    apply(a, b, cv, 8'hF0, 1'b0, 1'b1, 1'b0, 1'b1, "R8 long index");
    apply(a, b, cv, 8'hF0, 1'b0, 1'b1, 1'b0, 1'b0, "R8 short index");
    apply(a, b, cv, 8'h70, 1'b0, 1'b1, 1'b0, 1'b0, "R8 short index low");

    // R9 and all modes: random sweep, compared one cycle after drive
    for (int n = 0; n < N_RAND; n++) begin
      logic [7:0] im = 8'($urandom);
      logic [3:0] sel = 4'($urandom);
      apply(rnd256(), rnd256(), rnd256(), im, sel[0], sel[1], sel[2], sel[3],
            $sformatf("R9 random %0d mode %0d", n, im[1:0]));
    end

    @(negedge clk);
    check_head();
    done = 1;
    finish_run();
  end

endmodule